// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit is the read-after-write hazard control for a five-stage in-order integer pipeline with the stages fetch, decode, execute, memory and writeback. Operands are read from the register file during decode. Results are written during writeback. The register file writes in the first half of a cycle and reads in the second half, so decode already sees a value that is being written back in the same cycle. Write-after-read and write-after-write ordering cannot go wrong in this pipeline, which leaves only true dependences to resolve.

Each cycle the unit compares the two source register numbers of the instruction in decode against the destination fields of the execute-stage latch and the memory-stage latch. From that comparison it computes the operand-source selects that the instruction will need when it reaches execute, and registers them at the clock edge. The first forwarding source is the ALU output latch, which holds the result of the instruction one step ahead. The second is the writeback latch, which holds loaded data or an ALU result carried forward. When a load in execute produces a register that the decode instruction reads, the unit stalls the PC and the fetch/decode latch for one cycle and puts a no-op bubble into the execute latch. After that one bubble, the loaded value is forwarded from the writeback latch.

Top module: `hzd_fwd_unit`

## Requirements
- R1: While reset is held and after it is released, both operand selects read 00 (register file). In any cycle without a load-use hazard, stall and bubble are low.
- R2: Suppose a decode source is in use and equals the destination of an execute-stage instruction that writes a register and is not a load. Then after the next rising edge, that operand's select is 01 (ALU output latch).
- R3: Suppose a decode source is in use and equals the destination of a memory-stage instruction that writes a register, loads included. If no rule with higher priority applies, then after the next edge that operand's select is 10 (writeback latch).
- R4: When a decode source matches both the execute-stage producer and the memory-stage producer, the younger producer wins and the select becomes 01.
- R5: Suppose the execute-stage instruction is a register-writing load, and its destination equals a source that the decode instruction uses. Then stall and bubble are high in that same cycle, and after the edge both selects are 00.
- R6: After a load-use stall, the load has moved to the memory stage and the same decode instruction is still waiting. The operand that depends on the load then gets select 10 after the next edge.
- R7: Register 0 never causes forwarding or a stall, whatever the producer fields hold.
- R8: A producer whose register-write flag is clear never causes forwarding or a stall. This covers stores and branches.
- R9: A source whose use flag is low never causes forwarding or a stall.
- R10: A load in execute followed by a decode instruction that does not read its destination causes no stall and no bubble.
- R11: The select value 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_a | input | REG_AW | First source register of the decode instruction |
| dec_src_b | input | REG_AW | Second source register of the decode instruction |
| dec_use_a | input | 1 | First source is read |
| dec_use_b | input | 1 | Second source is read |
| exe_dst | input | REG_AW | Destination in the execute latch |
| exe_wen | input | 1 | Execute-latch instruction writes a register |
| exe_is_load | input | 1 | Execute-latch instruction is a load |
| mem_dst | input | REG_AW | Destination in the memory latch |
| mem_wen | input | 1 | Memory-latch instruction writes a register |
| opnd_a_sel | output | 2 | Source for the first ALU operand (00 register file, 01 ALU latch, 10 writeback latch) |
| opnd_b_sel | output | 2 | Source for the second ALU operand, same encoding |
| hold_front | output | 1 | Hold the PC and the fetch/decode latch |
| exe_bubble | output | 1 | Load a no-op into the execute latch |

## Verification
The bench aims at the cases where one slip sends the wrong value into the ALU. One is a source that matches both producers: a design with the priority reversed returns 10 instead of 01 and picks up stale data. Another is a load in execute: a design that treats it as an ALU producer forwards the address with no stall, and a design that stalls on a non-matching load (R10) loses a cycle. Register 0, cleared write flags and unused sources are driven against matching destinations to catch spurious forwarding. The stall-then-forward sequence checks that the bubble clears the selects and that the load data is then picked from the writeback latch.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_ALU     = 2'b01,
    SRC_WBK     = 2'b10
  } opnd_src_e;

  localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/hzd_operand_match.sv
module hzd_operand_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              src_used,
  input  logic [REG_AW-1:0] exe_dst,
  input  logic              exe_wen,
  input  logic              exe_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  output logic              hit_alu,
  output logic              hit_wbk,
  output logic              hit_load
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic live;
  logic exe_eq;
  logic mem_eq;

  always_comb begin
    live     = src_used && (src != ZERO_REG);
    exe_eq   = live && exe_wen && (exe_dst == src);
    mem_eq   = live && mem_wen && (mem_dst == src);
    hit_alu  = exe_eq && !exe_is_load;
    hit_load = exe_eq && exe_is_load;
    hit_wbk  = mem_eq;
  end

endmodule

// File: rtl/hzd_src_pick.sv
module hzd_src_pick
  import hzd_pkg::*;
(
  input  logic      hit_alu,
  input  logic      hit_wbk,
  input  logic      kill,
  output opnd_src_e src_next
);

  always_comb begin
    if (kill)         src_next = SRC_REGFILE;
    else if (hit_alu) src_next = SRC_ALU;
    else if (hit_wbk) src_next = SRC_WBK;
    else              src_next = SRC_REGFILE;
  end

endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  input  logic              dec_use_a,
  input  logic              dec_use_b,
  input  logic [REG_AW-1:0] exe_dst,
  input  logic              exe_wen,
  input  logic              exe_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  output logic [1:0]        opnd_a_sel,
  output logic [1:0]        opnd_b_sel,
  output logic              hold_front,
  output logic              exe_bubble
);

  logic [REG_AW-1:0] src_arr  [NUM_OPND];
  logic              used_arr [NUM_OPND];
  logic [NUM_OPND-1:0] hit_alu;
  logic [NUM_OPND-1:0] hit_wbk;
  logic [NUM_OPND-1:0] hit_load;
  opnd_src_e         src_next [NUM_OPND];
  opnd_src_e         src_q    [NUM_OPND];
  logic              load_use;

  assign src_arr[0]  = dec_src_a;
  assign src_arr[1]  = dec_src_b;
  assign used_arr[0] = dec_use_a;
  assign used_arr[1] = dec_use_b;

  // Interlock: a load in execute feeding either decode source.
  assign load_use   = |hit_load;
  assign hold_front = load_use;
  assign exe_bubble = load_use;

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    hzd_operand_match #(.REG_AW(REG_AW)) u_match (
      .src        (src_arr[i]),
      .src_used   (used_arr[i]),
      .exe_dst    (exe_dst),
      .exe_wen    (exe_wen),
      .exe_is_load(exe_is_load),
      .mem_dst    (mem_dst),
      .mem_wen    (mem_wen),
      .hit_alu    (hit_alu[i]),
      .hit_wbk    (hit_wbk[i]),
      .hit_load   (hit_load[i])
    );

    hzd_src_pick u_pick (
      .hit_alu (hit_alu[i]),
      .hit_wbk (hit_wbk[i]),
      .kill    (load_use),
      .src_next(src_next[i])
    );

    always_ff @(posedge clk) begin
      if (rst) src_q[i] <= SRC_REGFILE;
      else     src_q[i] <= src_next[i];
    end
  end

  assign opnd_a_sel = src_q[0];
  assign opnd_b_sel = src_q[1];

  AST_BUBBLE_CLEARS_SEL: assert property (@(posedge clk) disable iff (rst)
    hold_front |=> (opnd_a_sel == 2'b00 && opnd_b_sel == 2'b00)); // R5
  AST_NONLOAD_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    !exe_is_load |-> !hold_front); // R10
  AST_LOAD_NOT_ALU_SRC: assert property (@(posedge clk) disable iff (rst)
    exe_is_load |=> (opnd_a_sel != 2'b01 && opnd_b_sel != 2'b01)); // R2
  AST_ZERO_SRC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (dec_src_a == '0 && dec_src_b == '0) |-> !exe_bubble); // R7
  AST_NO_WRITER_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!exe_wen && !mem_wen) |=> (opnd_a_sel == 2'b00 && opnd_b_sel == 2'b00)); // R8
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (opnd_a_sel != 2'b11 && opnd_b_sel != 2'b11)); // R11

endmodule

// File: tb/tb_hzd_fwd_unit.sv
`timescale 1ns/1ps
module tb_hzd_fwd_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, exe_dst = '0, mem_dst = '0;
  logic dec_use_a = 0, dec_use_b = 0, exe_wen = 0, exe_is_load = 0, mem_wen = 0;
  logic [1:0] opnd_a_sel, opnd_b_sel;
  logic hold_front, exe_bubble;

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0] exp_a = 2'b00, exp_b = 2'b00;

  always #2.5 clk = ~clk;

  hzd_fwd_unit #(.REG_AW(AW)) dut (
    .clk(clk), .rst(rst),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
    .exe_dst(exe_dst), .exe_wen(exe_wen), .exe_is_load(exe_is_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen),
    .opnd_a_sel(opnd_a_sel), .opnd_b_sel(opnd_b_sel),
    .hold_front(hold_front), .exe_bubble(exe_bubble)
  );

  function automatic logic load_hit(input logic [AW-1:0] s, input logic u);
    return u && s != 0 && exe_wen && exe_is_load && exe_dst == s;
  endfunction

  function automatic logic model_stall();
    return load_hit(dec_src_a, dec_use_a) || load_hit(dec_src_b, dec_use_b);
  endfunction

  function automatic logic [1:0] model_sel(input logic [AW-1:0] s, input logic u);
    if (model_stall()) return 2'b00;
    if (!u || s == 0) return 2'b00;
    if (exe_wen && !exe_is_load && exe_dst == s) return 2'b01;
    if (mem_wen && mem_dst == s) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one decode/latch snapshot at the falling edge, check the
  // interlock in the same cycle and the registered selects after the edge.
  task automatic step(input string req,
                      input logic [AW-1:0] sa, input logic ua,
                      input logic [AW-1:0] sb, input logic ub,
                      input logic [AW-1:0] ed, input logic ew, input logic el,
                      input logic [AW-1:0] md, input logic mw);
    logic st;
    dec_src_a = sa; dec_use_a = ua; dec_src_b = sb; dec_use_b = ub;
    exe_dst = ed; exe_wen = ew; exe_is_load = el; mem_dst = md; mem_wen = mw;
    #1;
    st = model_stall();
    check({req, " stall"}, {1'b0, hold_front}, {1'b0, st});
    check({req, " bubble"}, {1'b0, exe_bubble}, {1'b0, st});
    exp_a = model_sel(sa, ua);
    exp_b = model_sel(sb, ub);
    @(negedge clk);
    check({req, " sel_a"}, opnd_a_sel, exp_a);
    check({req, " sel_b"}, opnd_b_sel, exp_b);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    // R1: reset holds selects at register file despite matching producers
    dec_src_a = 5'd3; dec_use_a = 1; exe_dst = 5'd3; exe_wen = 1;
    repeat (3) @(negedge clk);
    check("R1 reset sel_a", opnd_a_sel, 2'b00);
    check("R1 reset sel_b", opnd_b_sel, 2'b00);
    rst = 0;
    @(negedge clk);
    // R2: back-to-back dependent ALU ops
    step("R2", 5'd4, 1, 5'd7, 1, 5'd4, 1, 0, 5'd9, 1);
    step("R2 b", 5'd1, 1, 5'd6, 1, 5'd6, 1, 0, 5'd0, 0);
    // R3: producer two ahead, also a load
    step("R3", 5'd9, 1, 5'd2, 1, 5'd12, 1, 0, 5'd9, 1);
    // R4: both producers match
    step("R4", 5'd5, 1, 5'd5, 1, 5'd5, 1, 0, 5'd5, 1);
    // R5 then R6: load followed by dependent use
    step("R5", 5'd8, 1, 5'd3, 1, 5'd8, 1, 1, 5'd0, 0);
    step("R6", 5'd8, 1, 5'd3, 1, 5'd0, 0, 0, 5'd8, 1);
    // R5 on second operand
    step("R5 b", 5'd2, 1, 5'd11, 1, 5'd11, 1, 1, 5'd2, 1);
    // R10: load followed by independent instruction
    step("R10", 5'd1, 1, 5'd2, 1, 5'd8, 1, 1, 5'd2, 1);
    // R7: register 0
    step("R7", 5'd0, 1, 5'd0, 1, 5'd0, 1, 1, 5'd0, 1);
    // R8: store/branch ahead (no write flag)
    step("R8", 5'd6, 1, 5'd6, 1, 5'd6, 0, 1, 5'd6, 0);
    // R9: unused sources
    step("R9", 5'd6, 0, 5'd7, 0, 5'd6, 1, 1, 5'd7, 1);
    // Random mix with small register range to force collisions (R2-related
    // tags are assigned by outcome below; R11 checked on every sample).
    for (int i = 0; i < 2000; i++) begin
      logic [AW-1:0] sa, sb, ed, md;
      logic ua, ub, ew, el, mw;
      string tag;
      sa = AW'($urandom_range(0, 3)); sb = AW'($urandom_range(0, 3));
      ed = AW'($urandom_range(0, 3)); md = AW'($urandom_range(0, 3));
      ua = 1'($urandom); ub = 1'($urandom); ew = 1'($urandom);
      el = 1'($urandom); mw = 1'($urandom);
      tag = el ? "R5/R10 rnd" : (ew ? "R2/R4 rnd" : "R3/R8 rnd");
      step(tag, sa, ua, sb, ub, ed, ew, el, md, mw);
      check("R11 legal", {1'b0, opnd_a_sel == 2'b11 || opnd_b_sel == 2'b11}, 2'b00);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule